// File: doc/BRIEF.md
# PLL Register Controller with Two-Write Unlock

This block is the register front end for a clock-multiplier PLL. A simple bus with separate write and read strobes, a word address and 32-bit data reaches four registers: a reference-source select, a configuration word with a multiplier and a pre-divider, a control word with enable and connect, and a read-only status word. A fifth address, the feed port, takes the unlock sequence.

Software writes to configuration and control land in staging registers only. The staged values reach the outputs that drive the analog loop only when the feed port receives 0xAA and, on the very next bus access, 0x55. Any other bus access between those two abandons the sequence. A counter of reference cycles stands in for the analog lock detector. The outputs carry the committed multiplier and divider, enable, the effective connect and the effective source select.

Top module: `pll_ctl`

## Requirements
- R1: After reset every register and output is zero: disabled, disconnected, not locked, with no unlock sequence in progress.
- R2: The configuration word keeps the multiplier code (desired value minus one) in bits 14:0 and the pre-divider code (desired value minus one) in bits 23:16. Bits outside 0x00FF7FFF are dropped on write and read back as zero.
- R3: Writes to configuration (address 1) or control (address 2, bit 0 enable, bit 1 connect) read back at once, but they leave the committed outputs unchanged until a commit.
- R4: A write of 0xAA to the feed port (address 3, low byte compared), with the next bus access a write of 0x55 to that port, copies the staged configuration and control to the outputs at that second write's clock edge.
- R5: If any other access (a read, a write to another address, or a feed write with another value) comes between the 0xAA and the 0x55, nothing is committed. A repeated 0xAA restarts the sequence.
- R6: A 0x55 feed write that does not directly follow a 0xAA feed write commits nothing.
- R7: The status word (address 4) reads the committed multiplier in bits 14:0, the committed divider in bits 23:16, enable in bit 24, connect in bit 25 and lock in bit 26, with all other bits zero.
- R8: Lock rises LOCK_CYCLES clock cycles after a commit that enables the loop or changes the multiplier or divider while enabled. It drops at the commit edge when enable is cleared or either value changes. A commit with the same values and enable kept does not disturb it.
- R9: The connect output is high only while enable is committed, connect is committed and lock is high. A commit that clears enable also clears the committed connect.
- R10: The source select (address 0, 2 bits) takes effect on write without unlock and reads back as written. The output shows code 0 (internal RC), 1 (main oscillator) or 2 (RTC oscillator). The reserved code 3 drives 0 on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address: 0 source, 1 config, 2 control, 3 feed, 4 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high, zero otherwise |
| mult_o | output | 15 | Committed multiplier code |
| div_o | output | 8 | Committed pre-divider code |
| enable_o | output | 1 | Committed enable |
| connect_o | output | 1 | Effective connect |
| locked_o | output | 1 | Lock indicator |
| src_sel_o | output | 2 | Effective reference source |

## Verification
A corrupted unlock tracker shows up as outputs that change after an interrupted or unarmed sequence, or that stay put after a valid one. Either shows on the clock edge of the 0x55 write. A wrong lock counter shows as a lock edge one or more cycles off the LOCK_CYCLES mark, and as a connect output that rises too early or too late. The status read exposes committed state in the same cycle, so a divergence between staged and committed values appears on the first status read after a commit.

// File: rtl/pll_ctl.sv
module pll_ctl #(
  parameter int LOCK_CYCLES = 16,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [14:0]       mult_o,
  output logic [7:0]        div_o,
  output logic              enable_o,
  output logic              connect_o,
  output logic              locked_o,
  output logic [1:0]        src_sel_o
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);
  localparam logic [ADDR_W-1:0] A_SRC = 0, A_CFG = 1, A_CTL = 2, A_FEED = 3, A_STAT = 4;

  logic [1:0]       src_q;
  logic [14:0]      mult_stg, mult_q;
  logic [7:0]       div_stg, div_q;
  logic [1:0]       ctl_stg;
  logic             en_q, conn_q, lock_q, armed_q;
  logic [CNT_W-1:0] cnt_q;

  wire feed_wr = bus_wr && bus_addr == A_FEED;
  wire commit  = armed_q && feed_wr && bus_wdata[7:0] == 8'h55;
  wire changed = {div_stg, mult_stg} != {div_q, mult_q};
  wire restart = commit && (!ctl_stg[0] || !en_q || changed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      mult_stg <= '0;
      div_stg  <= '0;
      ctl_stg  <= '0;
      armed_q  <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_SRC) src_q <= bus_wdata[1:0];
      if (bus_wr && bus_addr == A_CFG) begin
        mult_stg <= bus_wdata[14:0];
        div_stg  <= bus_wdata[23:16];
      end
      if (bus_wr && bus_addr == A_CTL) ctl_stg <= bus_wdata[1:0];
      if (feed_wr && bus_wdata[7:0] == 8'hAA) armed_q <= 1'b1;
      else if (bus_wr || bus_rd)              armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= '0;
      div_q  <= '0;
      en_q   <= 1'b0;
      conn_q <= 1'b0;
    end else if (commit) begin
      mult_q <= mult_stg;
      div_q  <= div_stg;
      en_q   <= ctl_stg[0];
      conn_q <= ctl_stg[0] & ctl_stg[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (en_q && !lock_q) begin
      if (cnt_q == CNT_LAST) lock_q <= 1'b1;
      else                   cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_SRC:  bus_rdata = {30'd0, src_q};
        A_CFG:  bus_rdata = {8'd0, div_stg, 1'b0, mult_stg};
        A_CTL:  bus_rdata = {30'd0, ctl_stg};
        A_STAT: bus_rdata = {5'd0, lock_q, connect_o, en_q, div_q, 1'b0, mult_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign mult_o    = mult_q;
  assign div_o     = div_q;
  assign enable_o  = en_q;
  assign locked_o  = lock_q;
  assign connect_o = conn_q & en_q & lock_q;
  assign src_sel_o = (src_q == 2'd3) ? 2'd0 : src_q;
endmodule

// File: rtl/pll_ctl_chk.sv
module pll_ctl_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [14:0]       mult_o,
  input logic [7:0]        div_o,
  input logic              enable_o,
  input logic              connect_o,
  input logic              locked_o,
  input logic [1:0]        src_sel_o
);
  assert_cfg_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(1)) |-> (bus_rdata[31:24] == 8'd0 && bus_rdata[15] == 1'b0));

  assert_hold_without_feed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(3) && bus_wdata[7:0] == 8'h55)
      |=> ($stable(mult_o) && $stable(div_o) && $stable(enable_o)));

  assert_lock_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_o |-> !locked_o);

  assert_connect_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    connect_o |-> (enable_o && locked_o));

  assert_src_no_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel_o != 2'd3);
endmodule

bind pll_ctl pll_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_pll_ctl.sv
module sim_pll_ctl;
  localparam int L = 16;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [14:0] mult_o;
  logic [7:0] div_o;
  logic enable_o, connect_o, locked_o;
  logic [1:0] src_sel_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pll_ctl #(.LOCK_CYCLES(L), .ADDR_W(3)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 3'(a);
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic feed();
    wr(3, 32'hAA); wr(3, 32'h55);
  endtask

  function automatic logic [31:0] stat(logic [14:0] m, logic [7:0] n, logic e, c, k);
    return {5'd0, k, c, e, n, 1'b0, m};
  endfunction

  function automatic logic [31:0] outs();
    return stat(mult_o, div_o, enable_o, connect_o, locked_o);
  endfunction

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 outputs", {outs(), 30'd0, src_sel_o}, 64'd0 >> 32);
    chk("R1 src", {30'd0, src_sel_o}, 0);
    rd(4, d); chk("R1 status", d, 0);
    rd(1, d); chk("R1 cfg", d, 0);
    rd(2, d); chk("R1 ctl", d, 0);

    // R10 source select sweep
    for (int s = 0; s < 4; s++) begin
      wr(0, 32'hFFFF_FFFC | 32'(s));
      chk("R10 src out", {30'd0, src_sel_o}, (s == 3) ? 0 : s);
      rd(0, d); chk("R10 src readback", d, s);
    end

    // R2 field masking sweep
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v = 32'hDEAD_BEEF ^ (32'h1111_1111 * 32'(i)) ^ {i[3:0], 28'h0};
      wr(1, v);
      rd(1, d); chk("R2 cfg mask", d, v & 32'h00FF_7FFF);
    end

    // R3 staged writes hold outputs
    wr(1, 32'h0005_0063); wr(2, 32'h3);
    rd(2, d); chk("R3 ctl readback", d, 3);
    chk("R3 outputs unchanged", outs(), 0);

    // R6 lone 0x55
    wr(3, 32'h55);
    chk("R6 no commit", outs(), 0);

    // R5 abandoned sequences
    for (int k = 0; k < 4; k++) begin
      wr(3, 32'hAA);
      case (k)
        0: rd(4, d);
        1: wr(1, 32'h0005_0063);
        2: wr(3, 32'h12);
        default: wr(0, 32'h1);
      endcase
      wr(3, 32'h55);
      chk("R5 abandoned", outs(), 0);
    end

    // R4 commit with repeated 0xAA, then R8 lock timing
    wr(3, 32'hAA); wr(3, 32'hAA); wr(3, 32'h55);
    chk("R4 commit", outs(), stat(15'h63, 8'h05, 1, 0, 0));
    repeat (L - 1) @(negedge clk);
    chk("R8 not yet locked", {31'd0, locked_o}, 0);
    chk("R9 no connect before lock", {31'd0, connect_o}, 0);
    @(negedge clk);
    chk("R8 locked", {31'd0, locked_o}, 1);
    chk("R9 connect after lock", {31'd0, connect_o}, 1);
    rd(4, d); chk("R7 status", d, stat(15'h63, 8'h05, 1, 1, 1));

    // R8 same-value commit keeps lock
    feed();
    chk("R8 lock kept", {31'd0, locked_o}, 1);

    // R8 changed multiplier drops lock
    wr(1, 32'h0001_0010); feed();
    chk("R8 lock drop on change", outs(), stat(15'h10, 8'h01, 1, 0, 0));
    repeat (L) @(negedge clk);
    rd(4, d); chk("R7 status relock", d, stat(15'h10, 8'h01, 1, 1, 1));

    // R9 disable clears connect; re-enable without connect
    wr(2, 32'h0); feed();
    chk("R9 disable", outs(), stat(15'h10, 8'h01, 0, 0, 0));
    wr(2, 32'h1); feed();
    repeat (L) @(negedge clk);
    chk("R9 enable only", outs(), stat(15'h10, 8'h01, 1, 0, 1));

    // R7 status sweep over extremes
    for (int i = 0; i < 4; i++) begin
      logic [14:0] m = (i[0]) ? 15'h7FFF : 15'h0005;
      logic [7:0]  n = (i[1]) ? 8'hFF : 8'h00;
      wr(1, {8'hFF, n, 1'b1, m}); wr(2, 32'h3); feed();
      repeat (L) @(negedge clk);
      rd(4, d); chk("R7 status sweep", d, stat(m, n, 1, 1, 1));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule